// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the bus front end of a byte-wide flash memory and turns synchronous write cycles (an address plus a data byte) into memory commands. A command is only accepted as an exact series of address/data pairs. The first two writes of the series act as an unlock key. A correct series either changes the operating mode or fires a one-cycle start pulse towards the program/erase engine. Any write that breaks a series sends the decoder quietly back to plain read mode.

The decoder tracks five modes: normal array read, identifier read, fast-program (bypass) mode, engine busy, and fault. In bypass mode a program takes two writes and needs no unlock key. Read strobes return a registered source tag and byte. The byte is an identifier code in identifier mode, and a status byte with poll, toggle and error bits while the engine runs or after it has failed. The engine reports back through completion and failure pulses.

Top module: `cmdseq_decoder`

## Requirements
- R1: Command addresses are matched on write address bits 10:0 only. Upper bits are ignored (0xF555 matches 0x555 and 0x7AAA matches 0x2AA), and a write to 0x554 does not count as 0x555.
- R2: In read or identifier mode, a single write of 0xF0 to any address, or the series AA@555, 55@2AA, F0@any, leaves the decoder in read mode (mode code 0).
- R3: The series AA@555, 55@2AA, 90@555 enters identifier mode (mode code 1). The mode stays in force across reads until another command is written.
- R4: In identifier mode, a read with address bits 1:0 = 00 returns 0x20, a read with 01 returns 0x27, and a read with bit 1 = 1 returns 0x00. The source tag is 1 in each case.
- R5: The series AA@555, 55@2AA, A0@555, data@addr makes prog_start high for exactly one cycle, in the cycle after the fourth write. In that cycle op_addr and op_data hold that write's address and data, and the mode is busy (code 3).
- R6: The six-write series AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 makes erase_start high for one cycle after the last write and sets the mode to busy. prog_start and erase_start are never high together.
- R7: AA@555, 55@2AA, 20@555 enters bypass mode (code 2). In bypass mode, A0@any followed by data@addr starts a program, and 90@any followed by 00@any returns the decoder to read mode.
- R8: A write that does not match the expected step of a series returns the decoder to read mode, fires no pulse, and discards the steps already taken.
- R9: While busy, every write is ignored. A completion pulse returns the decoder to bypass mode if the operation began there, and to read mode otherwise.
- R10: In busy or fault mode, reads return source tag 2 and a status byte. Bit 7 is the inverse of bit 7 of the data being programmed (0 for an erase). Bit 6 starts at 0 when an operation starts and flips on each status read. Bit 5 is 1 only in fault mode.
- R11: A failure pulse while busy enters fault mode (code 4). In fault mode only a single 0xF0 write is accepted, and it returns the decoder to the mode that started the operation (bypass or read).
- R12: rd_valid is high in the cycle after rd_en. In read and bypass mode the source tag is 0 and the byte is 0x00. After reset the mode is read and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr_lo | input | 2 | Low two bits of the read address |
| eng_done | input | 1 | Engine completed successfully |
| eng_fail | input | 1 | Engine reported a failure |
| mode | output | 3 | 0 read, 1 identifier, 2 bypass, 3 busy, 4 fault |
| prog_start | output | 1 | One-cycle program start pulse |
| erase_start | output | 1 | One-cycle erase start pulse |
| op_addr | output | AW | Latched program address |
| op_data | output | 8 | Latched program data |
| rd_valid | output | 1 | Read result valid |
| rd_src | output | 2 | 0 array, 1 identifier, 2 status |
| rd_byte | output | 8 | Identifier or status byte |

## Verification
Every result sits exactly one register stage behind the strobe that causes it. A write captured on one rising edge shows up in the mode code and the start pulses right after that edge. A read shows up in rd_valid, rd_src and rd_byte one edge after rd_en, and an engine pulse shows up in the mode one edge later. The bench drives each strobe from a falling edge, holds it for one full cycle, removes it at the next falling edge, and samples there. Each check therefore lands in the single cycle in which a pulse exists. The cycle after it is checked as well, so a pulse that lasts too long or a state that is never held would be caught.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    MD_READ   = 3'd0,
    MD_IDENT  = 3'd1,
    MD_BYPASS = 3'd2,
    MD_BUSY   = 3'd3,
    MD_FAULT  = 3'd4
  } mode_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PDATA, ST_E1, ST_E2, ST_E3, ST_BPDATA, ST_BEXIT
  } step_t;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_STATUS = 2'd2
  } src_t;

  localparam logic [7:0] CD_KEY1     = 8'hAA;
  localparam logic [7:0] CD_KEY2     = 8'h55;
  localparam logic [7:0] CD_RESET    = 8'hF0;
  localparam logic [7:0] CD_IDENT    = 8'h90;
  localparam logic [7:0] CD_PROG     = 8'hA0;
  localparam logic [7:0] CD_BYPASS   = 8'h20;
  localparam logic [7:0] CD_ERASE    = 8'h80;
  localparam logic [7:0] CD_ERASE_GO = 8'h10;
endpackage

// File: rtl/fcs_match.sv
module fcs_match #(
  parameter int CW = 11,
  parameter logic [CW-1:0] KEY_A = 11'h555,
  parameter logic [CW-1:0] KEY_B = 11'h2AA
) (
  input  logic [CW-1:0] addr_lo,
  output logic          hit_a,
  output logic          hit_b
);
  assign hit_a = (addr_lo == KEY_A);
  assign hit_b = (addr_lo == KEY_B);
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          hit_a,
  input  logic          hit_b,
  input  logic          eng_done,
  input  logic          eng_fail,
  output mode_t         mode_q,
  output logic          launch,
  output logic          prog_start,
  output logic          erase_start,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          op_erase
);
  step_t step_q, step_d;
  mode_t mode_d;
  logic  byp_q, byp_d, pgo, ego;

  always_comb begin
    mode_d = mode_q;
    step_d = step_q;
    byp_d  = byp_q;
    pgo    = 1'b0;
    ego    = 1'b0;
    case (mode_q)
      MD_BUSY: begin
        if (eng_fail)      mode_d = MD_FAULT;
        else if (eng_done) mode_d = byp_q ? MD_BYPASS : MD_READ;
      end
      MD_FAULT: begin
        if (wr_en && wr_data == CD_RESET) mode_d = byp_q ? MD_BYPASS : MD_READ;
      end
      default: begin
        if (wr_en) begin
          step_d = ST_IDLE;
          case (step_q)
            ST_IDLE: begin
              if (mode_q == MD_BYPASS) begin
                if (wr_data == CD_PROG)       step_d = ST_BPDATA;
                else if (wr_data == CD_IDENT) step_d = ST_BEXIT;
                else                          mode_d = MD_READ;
              end else if (wr_data == CD_KEY1 && hit_a) step_d = ST_U1;
              else mode_d = MD_READ;
            end
            ST_U1: begin
              if (wr_data == CD_KEY2 && hit_b) step_d = ST_U2;
              else mode_d = MD_READ;
            end
            ST_U2: begin
              if (hit_a && wr_data == CD_IDENT)       mode_d = MD_IDENT;
              else if (hit_a && wr_data == CD_PROG)   step_d = ST_PDATA;
              else if (hit_a && wr_data == CD_BYPASS) mode_d = MD_BYPASS;
              else if (hit_a && wr_data == CD_ERASE)  step_d = ST_E1;
              else                                    mode_d = MD_READ;
            end
            ST_PDATA: begin
              pgo = 1'b1; mode_d = MD_BUSY; byp_d = 1'b0;
            end
            ST_E1: begin
              if (wr_data == CD_KEY1 && hit_a) step_d = ST_E2;
              else mode_d = MD_READ;
            end
            ST_E2: begin
              if (wr_data == CD_KEY2 && hit_b) step_d = ST_E3;
              else mode_d = MD_READ;
            end
            ST_E3: begin
              if (wr_data == CD_ERASE_GO && hit_a) begin
                ego = 1'b1; mode_d = MD_BUSY; byp_d = 1'b0;
              end else mode_d = MD_READ;
            end
            ST_BPDATA: begin
              pgo = 1'b1; mode_d = MD_BUSY; byp_d = 1'b1;
            end
            default: mode_d = MD_READ;
          endcase
        end
      end
    endcase
  end

  assign launch = pgo | ego;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MD_READ;
      step_q      <= ST_IDLE;
      byp_q       <= 1'b0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
      op_erase    <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      step_q      <= step_d;
      byp_q       <= byp_d;
      prog_start  <= pgo;
      erase_start <= ego;
      if (pgo) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
      if (launch) op_erase <= ego;
    end
  end

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_BUSY && !eng_done && !eng_fail) |=>
      (mode_q == MD_BUSY && !prog_start && !erase_start));
  assert_start_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start, erase_start}));
  assert_start_from_write_R5: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> $past(wr_en));
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);
  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_FAULT && !(wr_en && wr_data == CD_RESET)) |=> mode_q == MD_FAULT);
endmodule

// File: rtl/fcs_rdout.sv
module fcs_rdout
  import fcs_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h27
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_en,
  input  logic [1:0] rd_addr_lo,
  input  mode_t      mode_q,
  input  logic       launch,
  input  logic       op_erase,
  input  logic       op_bit7,
  output logic       rd_valid,
  output src_t       rd_src,
  output logic [7:0] rd_byte
);
  logic tgl_q;
  logic in_status;

  assign in_status = (mode_q == MD_BUSY) || (mode_q == MD_FAULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_src   <= SRC_ARRAY;
      rd_byte  <= 8'h00;
      tgl_q    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (launch) tgl_q <= 1'b0;
      else if (rd_en && in_status) tgl_q <= ~tgl_q;
      if (rd_en) begin
        if (in_status) begin
          rd_src  <= SRC_STATUS;
          rd_byte <= {(op_erase ? 1'b0 : ~op_bit7), tgl_q,
                      (mode_q == MD_FAULT), 5'b0};
        end else if (mode_q == MD_IDENT) begin
          rd_src  <= SRC_IDENT;
          rd_byte <= rd_addr_lo[1] ? 8'h00 : (rd_addr_lo[0] ? DEV_CODE : MFR_CODE);
        end else begin
          rd_src  <= SRC_ARRAY;
          rd_byte <= 8'h00;
        end
      end
    end
  end

  assert_rd_valid_R12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_toggle_flip_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_status && !launch && $past(rd_en) && $past(in_status) && rd_valid)
      |=> (rd_byte[6] != $past(rd_byte[6])));
endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
  import fcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr_lo,
  input  logic          eng_done,
  input  logic          eng_fail,
  output logic [2:0]    mode,
  output logic          prog_start,
  output logic          erase_start,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          rd_valid,
  output logic [1:0]    rd_src,
  output logic [7:0]    rd_byte
);
  logic  hit_a, hit_b, launch, op_erase;
  mode_t md;
  src_t  src;

  fcs_match #(.CW(CW)) u_match (
    .addr_lo(wr_addr[CW-1:0]), .hit_a(hit_a), .hit_b(hit_b)
  );

  fcs_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit_a(hit_a), .hit_b(hit_b), .eng_done(eng_done), .eng_fail(eng_fail),
    .mode_q(md), .launch(launch), .prog_start(prog_start),
    .erase_start(erase_start), .op_addr(op_addr), .op_data(op_data),
    .op_erase(op_erase)
  );

  fcs_rdout u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr_lo(rd_addr_lo),
    .mode_q(md), .launch(launch), .op_erase(op_erase), .op_bit7(op_data[7]),
    .rd_valid(rd_valid), .rd_src(src), .rd_byte(rd_byte)
  );

  assign mode   = md;
  assign rd_src = src;
endmodule

// File: tb/sim_cmdseq_decoder.sv
module sim_cmdseq_decoder;
  localparam int CLK_P = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, eng_done = 1'b0, eng_fail = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr_lo = '0;
  logic [2:0]  mode;
  logic        prog_start, erase_start, rd_valid;
  logic [15:0] op_addr;
  logic [7:0]  op_data, rd_byte;
  logic [1:0]  rd_src;
  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  cmdseq_decoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr_lo(rd_addr_lo), .eng_done(eng_done),
    .eng_fail(eng_fail), .mode(mode), .prog_start(prog_start),
    .erase_start(erase_start), .op_addr(op_addr), .op_data(op_data),
    .rd_valid(rd_valid), .rd_src(rd_src), .rd_byte(rd_byte)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1'b1; rd_addr_lo = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic eng(input bit fail);
    if (fail) eng_fail = 1'b1; else eng_done = 1'b1;
    @(negedge clk);
    eng_fail = 1'b0; eng_done = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  task automatic t_reset();
    chk("R12 mode after reset", mode, 3'd0);
    chk("R12 pulses after reset", {prog_start, erase_start, rd_valid}, 3'b000);
    rd(2'd0);
    chk("R12 read mode valid", rd_valid, 1'b1);
    chk("R12 read mode src/byte", {rd_src, rd_byte}, {2'd0, 8'h00});
    @(negedge clk);
    chk("R12 valid drops", rd_valid, 1'b0);
  endtask

  task automatic t_ident();
    unlock(); wr(16'h0555, 8'h90);
    chk("R3 ident entry", mode, 3'd1);
    rd(2'b00); chk("R4 mfr code", {rd_src, rd_byte}, {2'd1, 8'h20});
    rd(2'b01); chk("R4 dev code", {rd_src, rd_byte}, {2'd1, 8'h27});
    rd(2'b10); chk("R4 A1 high", {rd_src, rd_byte}, {2'd1, 8'h00});
    chk("R3 ident persists", mode, 3'd1);
    wr(16'h1234, 8'hF0);
    chk("R2 single reset", mode, 3'd0);
    unlock(); wr(16'h0555, 8'h90);
    unlock(); wr(16'h0000, 8'hF0);
    chk("R2 three-step reset", mode, 3'd0);
  endtask

  task automatic t_program();
    wr(16'hF555, 8'hAA); wr(16'h7AAA, 8'h55); wr(16'h0555, 8'hA0);
    wr(16'h1234, 8'h35);
    chk("R1 R5 prog pulse", {prog_start, erase_start}, 2'b10);
    chk("R5 op addr/data", {op_addr, op_data}, {16'h1234, 8'h35});
    chk("R5 busy", mode, 3'd3);
    rd(2'd0);
    chk("R5 pulse one cycle", prog_start, 1'b0);
    chk("R10 status 1st", {rd_src, rd_byte}, {2'd2, 8'h80});
    rd(2'd3);
    chk("R10 status toggled", rd_byte, 8'hC0);
    wr(16'h0000, 8'hF0);
    chk("R9 write ignored busy", mode, 3'd3);
    eng(1'b0);
    chk("R9 done to read", mode, 3'd0);
  endtask

  task automatic t_erase();
    unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h0555, 8'h10);
    chk("R6 erase pulse", {prog_start, erase_start}, 2'b01);
    chk("R6 busy", mode, 3'd3);
    rd(2'd0); chk("R10 erase status", rd_byte, 8'h00);
    chk("R6 pulse one cycle", erase_start, 1'b0);
    rd(2'd0); chk("R10 erase toggle", rd_byte, 8'h40);
    eng(1'b0);
    chk("R9 erase done", mode, 3'd0);
  endtask

  task automatic t_mismatch();
    unlock(); wr(16'h0554, 8'hA0); wr(16'h0100, 8'h77);
    chk("R8 no pulse after bad step", prog_start, 1'b0);
    chk("R8 read mode", mode, 3'd0);
    wr(16'h0554, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h77);
    chk("R1 low-bit mismatch", {prog_start, mode}, {1'b0, 3'd0});
    unlock(); wr(16'h0555, 8'h90);
    wr(16'h0555, 8'h33);
    chk("R8 ident to read", mode, 3'd0);
  endtask

  task automatic t_bypass();
    unlock(); wr(16'h0555, 8'h20);
    chk("R7 bypass entry", mode, 3'd2);
    rd(2'd0); chk("R12 bypass read", {rd_src, rd_byte}, {2'd0, 8'h00});
    wr(16'h0000, 8'hA0); wr(16'h4321, 8'h5A);
    chk("R7 bypass prog", {prog_start, op_addr, op_data, mode}, {1'b1, 16'h4321, 8'h5A, 3'd3});
    eng(1'b0);
    chk("R9 done to bypass", mode, 3'd2);
    wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
    chk("R7 bypass exit", mode, 3'd0);
  endtask

  task automatic t_fault();
    unlock(); wr(16'h0555, 8'h20);
    wr(16'h0000, 8'hA0); wr(16'h0010, 8'h81);
    eng(1'b1);
    chk("R11 fault entry", mode, 3'd4);
    rd(2'd0); chk("R10 R11 fault status", {rd_src, rd_byte}, {2'd2, 8'h20});
    wr(16'h0555, 8'hAA);
    chk("R11 other write blocked", mode, 3'd4);
    wr(16'h0000, 8'hF0);
    chk("R11 reset to bypass", mode, 3'd2);
    wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0020, 8'h01);
    eng(1'b1);
    wr(16'h0000, 8'hF0);
    chk("R11 reset to read", mode, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset(); t_ident(); t_program(); t_erase();
    t_mismatch(); t_bypass(); t_fault();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule